// File: doc/BRIEF.md
# Tiled Background Frame Renderer

This block paints one complete frame of a single background layer built from 8x8 tiles with two bits per pixel. After a start pulse it walks a grid of tilemap entries stored in byte-wide video RAM. For each entry it takes a 10-bit tile number and a 3-bit palette selector, then fetches the two interleaved plane bytes of every tile row. It turns each pixel into a 2-bit colour index, fetches the matching 16-bit colour word from a byte-wide palette RAM, and writes the colour into a frame buffer whose lines are 256 pixels apart.

The tilemap base comes from an 8-bit configuration value. Only its upper six bits count, and they are shifted up by nine, so the tilemap sits on a 2 KiB boundary. The tile pattern base is a byte address that the block takes as given. Both are latched when the start pulse is accepted. Every memory read has one cycle of latency. Each pixel costs two cycles in the inner loop, and the block raises `done` for one cycle after the last pixel has been written.

Top module: `bg_frame_render`

## Requirements
- R1: After reset, `done` and `fb_we` are low, and they stay low until a start pulse arrives.
- R2: The tilemap base is `(map_cfg & 0xFC) << 9`, reduced modulo the video RAM size. The entry for tile column tx and tile row ty is the byte pair at base + (ty*32 + tx)*2, low byte first.
- R3: In an entry, the first byte is tile number bits 7:0. Bits 1:0 of the second byte are tile number bits 9:8, and bits 4:2 of the second byte select the palette. Bits 7:5 of the second byte are ignored.
- R4: Tile t occupies 16 bytes starting at pattern base + t*16. Pixel row r reads plane 0 at offset 2r and plane 1 at offset 2r+1.
- R5: Pixel column j (0 = leftmost) uses bit 7-j of each plane byte. The plane 0 bit is colour bit 0 and the plane 1 bit is colour bit 1.
- R6: The palette index is palette*4 + colour. The colour word is little-endian at palette byte addresses 2*index and 2*index+1. `fb_data` carries bits 14:0 of that word, and bit 15 is always 0.
- R7: The pixel at screen (x, y) is written exactly once, to address y*256 + x. Writes go tile by tile (left to right, then top to bottom), and within a tile row by row, left to right. With default sizes this covers 256x224 pixels.
- R8: `done` is high for exactly one cycle, in the cycle right after the final pixel write.
- R9: A start pulse that arrives while a frame is in progress is ignored. The frame runs to the end unchanged.
- R10: Colour index 0 is looked up and written like any other index; no pixel is skipped or treated as transparent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to render a frame |
| map_cfg | input | 8 | Tilemap base configuration byte |
| pat_base | input | VRAM_AW | Pattern base byte address |
| vram_addr | output | VRAM_AW | Video RAM byte address |
| vram_data | input | 8 | Video RAM byte, one cycle after the address |
| pal_addr | output | PAL_AW | Palette RAM byte address |
| pal_data | input | 8 | Palette RAM byte, one cycle after the address |
| fb_we | output | 1 | Frame buffer write strobe |
| fb_addr | output | FB_AW | Frame buffer pixel address |
| fb_data | output | 16 | Pixel colour, bit 15 zero |
| done | output | 1 | One-cycle frame-complete pulse |

## Verification
A wrong tile, row or column counter shows up on `fb_addr` at the very next pixel write, because writes follow a fixed order. A stale tile number, palette selector or plane byte shows up as a wrong colour within the same row of eight pixels. The bench drives the memories from address-hashed content, so every fetch has a distinct expected value, and it compares each write against a reference computed from the requirements. A counter that ends the frame early or late moves `done` away from the cycle after the last expected write.

// File: rtl/bgr_pkg.sv
package bgr_pkg;

    localparam int TILE_PX       = 8;
    localparam int ENTRY_BYTES   = 2;
    localparam int PATTERN_BYTES = 16;

    typedef enum logic [3:0] {
        ST_IDLE = 4'd0,
        ST_MAP0 = 4'd1,
        ST_MAP1 = 4'd2,
        ST_HI   = 4'd3,
        ST_PAT0 = 4'd4,
        ST_PAT1 = 4'd5,
        ST_CAP1 = 4'd6,
        ST_PLO  = 4'd7,
        ST_PHI  = 4'd8,
        ST_WR   = 4'd9
    } rstate_e;

endpackage

// File: rtl/bgr_addr_calc.sv
module bgr_addr_calc #(
    parameter int AW       = 16,
    parameter int FB_AW    = 16,
    parameter int TXW      = 5,
    parameter int TYW      = 5,
    parameter int MAP_W    = 32,
    parameter int FB_PITCH = 256
) (
    input  logic [AW-1:0]    map_base,
    input  logic [AW-1:0]    pat_base,
    input  logic [TXW-1:0]   tx,
    input  logic [TYW-1:0]   ty,
    input  logic [9:0]       tile,
    input  logic [2:0]       row,
    input  logic [2:0]       col,
    input  logic             ent_hi,
    input  logic             plane_hi,
    output logic [AW-1:0]    ent_addr,
    output logic [AW-1:0]    pat_addr,
    output logic [FB_AW-1:0] fb_addr
);
    import bgr_pkg::*;

    always_comb begin
        ent_addr = map_base
                 + AW'((int'(ty) * MAP_W + int'(tx)) * ENTRY_BYTES + int'(ent_hi));
        pat_addr = pat_base
                 + AW'(int'(tile) * PATTERN_BYTES + int'(row) * 2 + int'(plane_hi));
        fb_addr  = FB_AW'((int'(ty) * TILE_PX + int'(row)) * FB_PITCH
                 + int'(tx) * TILE_PX + int'(col));
    end

endmodule

// File: rtl/bgr_pix_decode.sv
module bgr_pix_decode #(
    parameter int PAL_AW = 9
) (
    input  logic [7:0]        plane0,
    input  logic [7:0]        plane1,
    input  logic [2:0]        col,
    input  logic [2:0]        pal,
    input  logic              hi_sel,
    output logic [PAL_AW-1:0] pal_addr
);
    logic [2:0] bit_sel;
    logic [1:0] cidx;

    always_comb begin
        bit_sel  = 3'd7 - col;
        cidx     = {plane1[bit_sel], plane0[bit_sel]};
        pal_addr = PAL_AW'({pal, cidx, hi_sel});
    end

endmodule

// File: rtl/bg_frame_render.sv
module bg_frame_render #(
    parameter int VRAM_AW  = 16,
    parameter int PAL_AW   = 9,
    parameter int FB_AW    = 16,
    parameter int TILES_X  = 32,
    parameter int TILES_Y  = 28,
    parameter int MAP_W    = 32,
    parameter int FB_PITCH = 256
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [7:0]         map_cfg,
    input  logic [VRAM_AW-1:0] pat_base,
    output logic [VRAM_AW-1:0] vram_addr,
    input  logic [7:0]         vram_data,
    output logic [PAL_AW-1:0]  pal_addr,
    input  logic [7:0]         pal_data,
    output logic               fb_we,
    output logic [FB_AW-1:0]   fb_addr,
    output logic [15:0]        fb_data,
    output logic               done
);
    import bgr_pkg::*;

    localparam int TXW = (TILES_X > 1) ? $clog2(TILES_X) : 1;
    localparam int TYW = (TILES_Y > 1) ? $clog2(TILES_Y) : 1;
    localparam logic [TXW-1:0] TX_LAST = TXW'(TILES_X - 1);
    localparam logic [TYW-1:0] TY_LAST = TYW'(TILES_Y - 1);
    localparam logic [FB_AW-1:0] FB_LAST =
        FB_AW'((TILES_Y * TILE_PX - 1) * FB_PITCH + TILES_X * TILE_PX - 1);

    typedef struct packed {
        rstate_e            st;
        logic [TXW-1:0]     tx;
        logic [TYW-1:0]     ty;
        logic [2:0]         row;
        logic [2:0]         col;
        logic [VRAM_AW-1:0] map_base;
        logic [VRAM_AW-1:0] pat_base;
        logic [7:0]         lo;
        logic [9:0]         tile;
        logic [2:0]         pal;
        logic [7:0]         p0;
        logic [7:0]         p1;
        logic [7:0]         clo;
        logic               done;
    } rstate_t;

    rstate_t r_q, r_d;

    logic [31:0]        map_full;
    logic               ent_hi, plane_hi, pal_hi;
    logic [2:0]         dec_col;
    logic [VRAM_AW-1:0] ent_addr, pat_addr;

    assign map_full = 32'({map_cfg[7:2], 2'b00}) << 9;
    assign ent_hi   = (r_q.st == ST_MAP1);
    assign plane_hi = (r_q.st == ST_PAT1);
    assign pal_hi   = (r_q.st == ST_PHI);
    assign dec_col  = (r_q.st == ST_WR) ? r_q.col + 3'd1 : r_q.col;

    bgr_addr_calc #(
        .AW(VRAM_AW), .FB_AW(FB_AW), .TXW(TXW), .TYW(TYW),
        .MAP_W(MAP_W), .FB_PITCH(FB_PITCH)
    ) u_addr (
        .map_base (r_q.map_base),
        .pat_base (r_q.pat_base),
        .tx       (r_q.tx),
        .ty       (r_q.ty),
        .tile     (r_q.tile),
        .row      (r_q.row),
        .col      (r_q.col),
        .ent_hi   (ent_hi),
        .plane_hi (plane_hi),
        .ent_addr (ent_addr),
        .pat_addr (pat_addr),
        .fb_addr  (fb_addr)
    );

    bgr_pix_decode #(.PAL_AW(PAL_AW)) u_dec (
        .plane0   (r_q.p0),
        .plane1   (r_q.p1),
        .col      (dec_col),
        .pal      (r_q.pal),
        .hi_sel   (pal_hi),
        .pal_addr (pal_addr)
    );

    always_comb begin
        case (r_q.st)
            ST_MAP0, ST_MAP1: vram_addr = ent_addr;
            ST_PAT0, ST_PAT1: vram_addr = pat_addr;
            default:          vram_addr = '0;
        endcase
    end

    assign fb_we   = (r_q.st == ST_WR);
    assign fb_data = {pal_data, r_q.clo} & 16'h7FFF;
    assign done    = r_q.done;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.st       = ST_MAP0;
                    r_d.map_base = map_full[VRAM_AW-1:0];
                    r_d.pat_base = pat_base;
                    r_d.tx       = '0;
                    r_d.ty       = '0;
                    r_d.row      = '0;
                    r_d.col      = '0;
                end
            end
            ST_MAP0: r_d.st = ST_MAP1;
            ST_MAP1: begin
                r_d.lo = vram_data;
                r_d.st = ST_HI;
            end
            ST_HI: begin
                r_d.tile = {vram_data[1:0], r_q.lo};
                r_d.pal  = vram_data[4:2];
                r_d.st   = ST_PAT0;
            end
            ST_PAT0: r_d.st = ST_PAT1;
            ST_PAT1: begin
                r_d.p0 = vram_data;
                r_d.st = ST_CAP1;
            end
            ST_CAP1: begin
                r_d.p1 = vram_data;
                r_d.st = ST_PLO;
            end
            ST_PLO: r_d.st = ST_PHI;
            ST_PHI: begin
                r_d.clo = pal_data;
                r_d.st  = ST_WR;
            end
            ST_WR: begin
                if (r_q.col != 3'd7) begin
                    r_d.col = r_q.col + 3'd1;
                    r_d.st  = ST_PHI;
                end else begin
                    r_d.col = '0;
                    if (r_q.row != 3'd7) begin
                        r_d.row = r_q.row + 3'd1;
                        r_d.st  = ST_PAT0;
                    end else begin
                        r_d.row = '0;
                        if (r_q.tx != TX_LAST) begin
                            r_d.tx = r_q.tx + 1'b1;
                            r_d.st = ST_MAP0;
                        end else begin
                            r_d.tx = '0;
                            if (r_q.ty != TY_LAST) begin
                                r_d.ty = r_q.ty + 1'b1;
                                r_d.st = ST_MAP0;
                            end else begin
                                r_d.st   = ST_IDLE;
                                r_d.done = 1'b1;
                            end
                        end
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(fb_we) && $past(fb_addr) == FB_LAST));

    // R2
    ent_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_MAP1) |-> (vram_addr - $past(vram_addr)) == VRAM_AW'(1));

    // R4
    plane_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_PAT1) |-> (vram_addr - $past(vram_addr)) == VRAM_AW'(1));

    // R6
    pal_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fb_we |-> ($past(pal_addr) == ($past(pal_addr, 2) | PAL_AW'(1))));

    // R7
    fb_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fb_we && fb_addr[2:0] != 3'd0) |-> (fb_addr - $past(fb_addr, 2)) == FB_AW'(1));

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_IDLE) |-> !fb_we);

endmodule

// File: tb/bg_frame_render_test.sv
`timescale 1ns/1ps
module bg_frame_render_test;

    localparam int TX   = 32;
    localparam int TY   = 2;
    localparam int NPIX = TX * TY * 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  map_cfg = 8'h00;
    logic [15:0] pat_base = 16'h0000;
    logic [15:0] vram_addr;
    logic [7:0]  vram_data = 8'h00;
    logic [8:0]  pal_addr;
    logic [7:0]  pal_data = 8'h00;
    logic        fb_we;
    logic [15:0] fb_addr;
    logic [15:0] fb_data;
    logic        done;

    always #5 clk = ~clk;

    bg_frame_render #(.TILES_X(TX), .TILES_Y(TY)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .map_cfg(map_cfg),
        .pat_base(pat_base), .vram_addr(vram_addr), .vram_data(vram_data),
        .pal_addr(pal_addr), .pal_data(pal_data), .fb_we(fb_we),
        .fb_addr(fb_addr), .fb_data(fb_data), .done(done)
    );

    int n_tests = 0;
    int n_fail  = 0;
    logic [7:0] vseed = 8'h00;
    logic [7:0] pseed = 8'h00;
    int vmode = 0;

    function automatic logic [7:0] vbyte(logic [15:0] a);
        if (vmode == 1) return 8'h00;
        return 8'(a[7:0] * 8'd37) ^ a[15:8] ^ {a[3:0], 4'h0} ^ vseed;
    endfunction

    function automatic logic [7:0] pbyte(logic [8:0] a);
        return 8'(a * 9'd29) ^ (a[8] ? 8'h5A : 8'h00) ^ pseed;
    endfunction

    always @(posedge clk) begin
        vram_data <= vbyte(vram_addr);
        pal_data  <= pbyte(pal_addr);
    end

    function automatic logic [15:0] ref_pix(int x, int y);
        int tx, ty, r, c, pal, col;
        logic [15:0] base, ea, pa;
        logic [7:0] lo, hi, p0, p1;
        logic [9:0] tile;
        logic [8:0] idx;
        tx = x / 8; c = x % 8; ty = y / 8; r = y % 8;
        base = 16'(32'({map_cfg[7:2], 2'b00}) << 9);
        ea   = base + 16'((ty * 32 + tx) * 2);
        lo   = vbyte(ea);
        hi   = vbyte(ea + 16'd1);
        tile = {hi[1:0], lo};
        pal  = int'(hi[4:2]);
        pa   = pat_base + 16'(int'(tile) * 16 + r * 2);
        p0   = vbyte(pa);
        p1   = vbyte(pa + 16'd1);
        col  = {30'd0, p1[7 - c], p0[7 - c]};
        idx  = 9'((pal * 4 + col) * 2);
        return {pbyte(idx + 9'd1), pbyte(idx)} & 16'h7FFF;
    endfunction

    function automatic int ord_addr(int n);
        int t, r, c;
        t = n / 64; r = (n / 8) % 8; c = n % 8;
        return ((t / TX) * 8 + r) * 256 + (t % TX) * 8 + c;
    endfunction

    int cyc = 0, wr_n = 0, addr_err = 0, data_err = 0;
    int last_we_cyc = -1, done_cyc = -1, done_cnt = 0;
    logic [15:0] bad_act, bad_exp;

    always @(negedge clk) begin
        cyc++;
        if (fb_we) begin
            if (int'(fb_addr) != ord_addr(wr_n)) addr_err++;
            if (fb_data != ref_pix(int'(fb_addr) % 256, int'(fb_addr) / 256)) begin
                if (data_err == 0) begin
                    bad_act = fb_data;
                    bad_exp = ref_pix(int'(fb_addr) % 256, int'(fb_addr) / 256);
                end
                data_err++;
            end
            wr_n++;
            last_we_cyc = cyc;
        end
        if (done) begin
            done_cnt++;
            done_cyc = cyc;
        end
    end

    task automatic chk(string tag, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic run_frame(int restart_at);
        int waited;
        wr_n = 0; addr_err = 0; data_err = 0; done_cnt = 0;
        last_we_cyc = -1; done_cyc = -1;
        @(negedge clk); #1 start = 1'b1;
        @(negedge clk); #1 start = 1'b0;
        waited = 0;
        while (done_cnt == 0 && waited < 60000) begin
            @(negedge clk); #1;
            waited++;
            if (waited == restart_at) begin
                start = 1'b1;
                @(negedge clk); #1 start = 1'b0;
            end
        end
        repeat (3) @(negedge clk);
        #1;
    endtask

    task automatic frame_checks(string tag);
        chk({tag, " data"}, data_err, 0);
        if (data_err != 0) chk({tag, " first pixel"}, int'(bad_act), int'(bad_exp));
        chk("R7 write order", addr_err, 0);
        chk("R7 write count", wr_n, NPIX);
        chk("R8 done timing", done_cyc, last_we_cyc + 1);
        chk("R8 single done", done_cnt, 1);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        chk("R1 done in reset", int'(done), 0);
        chk("R1 we in reset", int'(fb_we), 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        #1;
        chk("R1 idle done", int'(done), 0);
        chk("R1 idle writes", wr_n, 0);
    endtask

    // R2 R3 R4 R5 R6: hashed content, base zero
    task automatic t_basic();
        vmode = 0; vseed = 8'h3C; pseed = 8'h11;
        map_cfg = 8'h00; pat_base = 16'h0000;
        run_frame(0);
        frame_checks("R3 R5 basic");
    endtask

    // R2: low cfg bits ignored, base wraps; R4 nonzero pattern base
    task automatic t_bases();
        vmode = 0; vseed = 8'hA7; pseed = 8'hC2;
        map_cfg = 8'hFF; pat_base = 16'h4321;
        run_frame(0);
        frame_checks("R2 R4 bases");
        map_cfg = 8'h17; pat_base = 16'hFFF0;
        run_frame(0);
        frame_checks("R6 R4 wrap");
    endtask

    // R10: all-zero planes give colour 0 which is still looked up
    task automatic t_zero();
        vmode = 1; pseed = 8'h9E;
        map_cfg = 8'h08; pat_base = 16'h0100;
        run_frame(0);
        frame_checks("R10 colour0");
        chk("R10 no skipped pixels", wr_n, NPIX);
        vmode = 0;
    endtask

    // R9: a second start during the frame changes nothing
    task automatic t_busy();
        vmode = 0; vseed = 8'h55; pseed = 8'h02;
        map_cfg = 8'h40; pat_base = 16'h2000;
        run_frame(2500);
        frame_checks("R9 busy");
        chk("R9 order kept", addr_err, 0);
        repeat (20) @(negedge clk);
        #1;
        chk("R9 no restart", wr_n, NPIX);
    endtask

    initial begin
        t_reset();
        t_basic();
        t_bases();
        t_zero();
        t_busy();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=<190000 cycles", cyc);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule